// File: doc/BRIEF.md
# Bridge Configuration Header Register File

This block holds the sixteen dwords of a bridge-type (Type-1) configuration header and serves byte, word and dword accesses to them. Each bit follows a fixed access policy. Read-only bits hold constants set at reset. Read-write bits take write data. Write-one-to-clear bits are set by hardware error events and cleared by software. Reserved bits always read as zero. A host controller that has no real root-port bridge places this block behind its configuration access path, so that enumeration software finds a well-formed bridge header.

A request is one cycle long. It carries a 6-bit byte address, a size code, a write flag and write data, with the data justified to the low byte lanes. A write changes the header on the clock edge where the request is sampled. Read data and the error flag are registered and appear one clock later. Two static configuration inputs turn off I/O forwarding or prefetchable-memory forwarding. When one is set, the related window registers become read-only. Two event inputs set the primary and secondary status error bits.

Top module: `bridge_cfg_hdr`

## Requirements
- R1: After reset, dword 0 reads ID_WORD and dword 2 reads {24'h060400, REV}. Dword 3 reads 0x00010010, which is cache line size 0x10 and header type 1. Dword 1 reads 0x00100000, with the capability-list bit 20 set. Dword 9 reads 0x00010001, dword 13 reads CAP_PTR and dword 15 reads INT_PIN in bits 15:8. Every other dword reads 0, and both rsp_err and rsp_rdata are 0.
- R2: Read data appears on rsp_rdata one clock after the read request. Reserved bits, meaning bits that are neither RO, RW nor W1C, read as zero. In dword 15 these include bits 31:23.
- R3: For a 1-byte or 2-byte read, the addressed dword is shifted right by 8 times addr[1:0] and masked to 8 or 16 bits. A 4-byte access ignores addr[1:0].
- R4: A size code other than 1, 2 or 4 sets rsp_err one clock later, and a write with such a code changes nothing. rsp_err is 0 after every valid-size request and after every idle cycle.
- R5: A 1-byte or 2-byte write shifts its data left by 8 times addr[1:0] and touches only the byte lanes that land inside the dword. Lanes beyond byte 3 are dropped.
- R6: Dwords 0, 2, 3, 4, 5, 13 and 14 are fully read-only, and RO bits never change on a write.
- R7: In dword 1, command bits 0 (I/O), 1 (memory), 2 (bus master), 6 (parity) and 8 (SERR) are RW. In dword 6, bits 23:0 (bus numbers) are RW and bits 31:24 are RO zero.
- R8: Bits 24 and 31:27 of dword 1 are W1C. They are set by pri_err_set[0] and pri_err_set[5:1]. The same bits of dword 7 work the same way from sec_err_set. Writing 1 to such a bit clears it, and writing 0 leaves it alone. A set event in the same cycle as a clear wins.
- R9: In dword 7, bits 15:12 and 7:4 are RW. In dwords 8 and 9, bits 31:20 and 15:4 are RW, and bits 19:16 and 3:0 are RO.
- R10: Dwords 10, 11 and 12 are fully RW.
- R11: In dword 15, bits 7:0 are RW, bits 15:8 are RO, and bridge-control bits 16, 17, 18, 19 and 22 are RW.
- R12: While io_fwd_off is 1, command bit 0, bits 15:0 of dword 7 and all of dword 12 ignore writes.
- R13: While pref_fwd_off is 1, dword 9 ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_fwd_off | input | 1 | Disables I/O forwarding registers |
| pref_fwd_off | input | 1 | Disables prefetchable window register |
| pri_err_set | input | 6 | Sets primary status error bits |
| sec_err_set | input | 6 | Sets secondary status error bits |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address within the header |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, low-lane justified |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Registered bad-size flag |

## Verification
The bench sets ID_WORD, REV, INT_PIN and CAP_PTR to distinct non-default patterns. This way a swapped byte, a wrong lane shift or a constant that leaks into the wrong dword shows up as a wrong value at the port. The nonzero CAP_PTR and INT_PIN also make the masks of the read-only bytes in dwords 13 and 15 visible. Both forwarding inputs are toggled at run time, so each policy variant is checked against data written before the switch.

// File: rtl/bridge_cfg_hdr.sv
module bridge_cfg_hdr #(
  parameter logic [31:0] ID_WORD = 32'h0001_1AB5,
  parameter logic [7:0]  REV     = 8'h01,
  parameter logic [7:0]  INT_PIN = 8'h01,
  parameter logic [7:0]  CAP_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_fwd_off,
  input  logic        pref_fwd_off,
  input  logic [5:0]  pri_err_set,
  input  logic [5:0]  sec_err_set,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [5:0]  req_addr,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err
);

  localparam int NDW = 16;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] ERR_BITS = 32'hF900_0000;

  logic [31:0] regs [NDW];

  function automatic logic [31:0] rw_mask(input int i, input logic io_off, input logic pf_off);
    case (i)
      1:       return io_off ? 32'h0000_0146 : 32'h0000_0147;
      6:       return 32'h00FF_FFFF;
      7:       return io_off ? 32'h0 : 32'h0000_F0F0;
      8:       return 32'hFFF0_FFF0;
      9:       return pf_off ? 32'h0 : 32'hFFF0_FFF0;
      10, 11:  return ONES;
      12:      return io_off ? 32'h0 : ONES;
      15:      return 32'h004F_00FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ro_mask(input int i, input logic io_off, input logic pf_off);
    case (i)
      0, 2, 3, 4, 5, 14: return ONES;
      1:       return io_off ? 32'h06B0_02B9 : 32'h06B0_02B8;
      6:       return 32'hFF00_0000;
      7:       return io_off ? 32'h06A0_FFFF : 32'h06A0_0F0F;
      8:       return 32'h000F_000F;
      9:       return pf_off ? ONES : 32'h000F_000F;
      12:      return io_off ? ONES : 32'h0;
      13:      return 32'h0000_00FF;
      15:      return 32'h0000_FF00;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] w1c_mask(input int i);
    return (i == 1 || i == 7) ? ERR_BITS : 32'h0;
  endfunction

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      0:       return ID_WORD;
      1:       return 32'h0010_0000;
      2:       return {24'h060400, REV};
      3:       return 32'h0001_0010;
      9:       return 32'h0001_0001;
      13:      return {24'h0, CAP_PTR};
      15:      return {16'h0, INT_PIN, 8'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] err_expand(input logic [5:0] e);
    return {e[5:1], 2'b00, e[0], 24'h0};
  endfunction

  logic        size_ok;
  logic [1:0]  sh;
  logic [4:0]  shamt;
  logic [3:0]  idx;
  logic [31:0] lane, wd, rword, rshift;

  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign sh      = (req_size == 3'd4) ? 2'd0 : req_addr[1:0];
  assign shamt   = {sh, 3'b000};
  assign idx     = req_addr[5:2];
  assign lane    = (req_size == 3'd1) ? (32'h0000_00FF << shamt) :
                   (req_size == 3'd2) ? (32'h0000_FFFF << shamt) : ONES;
  assign wd      = req_wdata << shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDW; i++) regs[i] <= rst_val(i);
    end else begin
      for (int i = 0; i < NDW; i++) begin
        logic [31:0] nxt, rwm, w1m;
        rwm = rw_mask(i, io_fwd_off, pref_fwd_off) & lane;
        w1m = w1c_mask(i) & lane;
        nxt = regs[i];
        if (req_valid && req_write && size_ok && (idx == 4'(i))) begin
          nxt = (nxt & ~rwm) | (wd & rwm);
          nxt = nxt & ~(wd & w1m);
        end
        if (i == 1) nxt = nxt | err_expand(pri_err_set);
        if (i == 7) nxt = nxt | err_expand(sec_err_set);
        regs[i] <= nxt;
      end
    end
  end

  always_comb begin
    rword = 32'h0;
    for (int i = 0; i < NDW; i++)
      if (idx == 4'(i))
        rword = regs[i] & (ro_mask(i, io_fwd_off, pref_fwd_off) |
                           rw_mask(i, io_fwd_off, pref_fwd_off) | w1c_mask(i));
  end

  assign rshift = rword >> shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= 32'h0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_err <= req_valid && !size_ok;
      if (req_valid && !req_write && size_ok)
        rsp_rdata <= (req_size == 3'd1) ? {24'h0, rshift[7:0]} :
                     (req_size == 3'd2) ? {16'h0, rshift[15:0]} : rword;
    end
  end

  assert_id_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 3'd4 && req_addr[5:2] == 4'd0)
      |=> rsp_rdata == ID_WORD);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 3'd4 && req_addr[5:2] == 4'd15)
      |=> rsp_rdata[31:23] == 9'h0);

  assert_bad_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !size_ok) |=> rsp_err);

  assert_idle_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_err);

  assert_err_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pri_err_set[0] |=> regs[1][24]);

  assert_io_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    io_fwd_off |=> $stable(regs[12]));

  assert_pref_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    pref_fwd_off |=> $stable(regs[9]));

endmodule

// File: tb/test_bridge_cfg_hdr.sv
`timescale 1ns/1ps
module test_bridge_cfg_hdr;

  localparam logic [31:0] T_ID  = 32'h5A5A_1B2C;
  localparam logic [7:0]  T_REV = 8'h07;
  localparam logic [7:0]  T_PIN = 8'h02;
  localparam logic [7:0]  T_CAP = 8'h40;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_fwd_off = 0, pref_fwd_off = 0;
  logic [5:0]  pri_err_set = 0, sec_err_set = 0;
  logic        req_valid = 0, req_write = 0;
  logic [5:0]  req_addr = 0;
  logic [2:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bridge_cfg_hdr #(.ID_WORD(T_ID), .REV(T_REV), .INT_PIN(T_PIN), .CAP_PTR(T_CAP)) i_bridge_cfg_hdr (
    .clk(clk), .rst_n(rst_n), .io_fwd_off(io_fwd_off), .pref_fwd_off(pref_fwd_off),
    .pri_err_set(pri_err_set), .sec_err_set(sec_err_set),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  // {write, addr, size, wdata, expected read}
  localparam int NV = 26;
  localparam logic [73:0] VEC [NV] = '{
    {1'b1, 6'h04, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R7 command
    {1'b0, 6'h04, 3'd4, 32'h0,         32'h0010_0147},
    {1'b1, 6'h00, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R6 id
    {1'b0, 6'h00, 3'd4, 32'h0,         32'h5A5A_1B2C},
    {1'b1, 6'h19, 3'd1, 32'h0000_00AB, 32'h0},          // R5 byte write
    {1'b0, 6'h18, 3'd4, 32'h0,         32'h0000_AB00},
    {1'b1, 6'h1A, 3'd2, 32'h0000_FFCD, 32'h0},          // R5/R7 upper half
    {1'b0, 6'h18, 3'd4, 32'h0,         32'h00CD_AB00},
    {1'b0, 6'h1A, 3'd1, 32'h0,         32'h0000_00CD},  // R3
    {1'b0, 6'h19, 3'd2, 32'h0,         32'h0000_CDAB},  // R3
    {1'b1, 6'h1C, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R9 io
    {1'b0, 6'h1C, 3'd4, 32'h0,         32'h0000_F0F0},
    {1'b1, 6'h20, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R9 mem
    {1'b0, 6'h20, 3'd4, 32'h0,         32'hFFF0_FFF0},
    {1'b1, 6'h24, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R9 pref
    {1'b0, 6'h24, 3'd4, 32'h0,         32'hFFF1_FFF1},
    {1'b1, 6'h28, 3'd4, 32'h1234_5678, 32'h0},          // R10
    {1'b1, 6'h2C, 3'd4, 32'h9ABC_DEF0, 32'h0},
    {1'b1, 6'h30, 3'd4, 32'hCAFE_BEEF, 32'h0},
    {1'b0, 6'h2C, 3'd4, 32'h0,         32'h9ABC_DEF0},
    {1'b1, 6'h2B, 3'd2, 32'h0000_FF11, 32'h0},          // R5 lane drop
    {1'b0, 6'h28, 3'd4, 32'h0,         32'h1134_5678},
    {1'b1, 6'h3C, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R11
    {1'b0, 6'h3C, 3'd4, 32'h0,         32'h004F_02FF},
    {1'b0, 6'h0B, 3'd2, 32'h0,         32'h0000_0006},  // R3 offset 3
    {1'b0, 6'h0E, 3'd4, 32'h0,         32'h0001_0010}   // R3 size 4
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic op(input bit w, input logic [5:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [2:0] s, input logic [31:0] exp);
    op(0, a, s, 32'h0);
    check(tag, rsp_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rdata at reset", rsp_rdata, 32'h0);
    check("R1 err at reset", {31'h0, rsp_err}, 32'h0);
    rd("R1 dword0", 6'h00, 3'd4, T_ID);
    rd("R1 dword1", 6'h04, 3'd4, 32'h0010_0000);
    rd("R1 dword2", 6'h08, 3'd4, {24'h060400, T_REV});
    rd("R1 dword3", 6'h0C, 3'd4, 32'h0001_0010);
    rd("R1 dword9", 6'h24, 3'd4, 32'h0001_0001);
    rd("R1 dword13", 6'h34, 3'd4, {24'h0, T_CAP});
    rd("R1 dword15", 6'h3C, 3'd4, {16'h0, T_PIN, 8'h0});
    rd("R1 dword10", 6'h28, 3'd4, 32'h0);
    rd("R2 byte read id", 6'h03, 3'd1, 32'h0000_005A);

    for (int k = 0; k < NV; k++) begin
      logic [73:0] v;
      v = VEC[k];
      op(v[73], v[72:67], v[66:64], v[63:32]);
      if (!v[73]) check($sformatf("R5/R9/R10 vector %0d", k), rsp_rdata, v[31:0]);
    end

    rd("R6 dword13 after write", 6'h34, 3'd4, {24'h0, T_CAP});
    op(1, 6'h0C, 3'd4, 32'hFFFF_FFFF);
    rd("R6 dword3 after write", 6'h0C, 3'd4, 32'h0001_0010);
    rd("R6 dword4 after write", 6'h10, 3'd4, 32'h0);
    op(1, 6'h10, 3'd4, 32'hFFFF_FFFF);
    rd("R6 BAR stays zero", 6'h10, 3'd4, 32'h0);

    op(1, 6'h28, 3'd3, 32'h0);
    check("R4 bad size write err", {31'h0, rsp_err}, 32'h1);
    rd("R4 bad size write ignored", 6'h28, 3'd4, 32'h1134_5678);
    check("R4 err clear after good op", {31'h0, rsp_err}, 32'h0);
    op(0, 6'h00, 3'd0, 32'h0);
    check("R4 bad size read err", {31'h0, rsp_err}, 32'h1);
    @(negedge clk);
    check("R4 idle clears err", {31'h0, rsp_err}, 32'h0);

    @(negedge clk); pri_err_set = 6'h3F;
    @(negedge clk); pri_err_set = 6'h00;
    rd("R8 primary set", 6'h04, 3'd4, 32'hF910_0147);
    op(1, 6'h07, 3'd1, 32'h0000_0009);
    rd("R8 clear bits 24 27", 6'h04, 3'd4, 32'hF010_0147);
    op(1, 6'h04, 3'd4, 32'h0000_0147);
    rd("R8 write zero keeps", 6'h04, 3'd4, 32'hF010_0147);
    @(negedge clk);
    pri_err_set = 6'h02;
    req_valid = 1; req_write = 1; req_addr = 6'h07; req_size = 3'd1; req_wdata = 32'h08;
    @(negedge clk);
    req_valid = 0; req_write = 0; pri_err_set = 6'h00;
    rd("R8 set wins over clear", 6'h04, 3'd4, 32'hF810_0147);
    @(negedge clk); sec_err_set = 6'h21;
    @(negedge clk); sec_err_set = 6'h00;
    rd("R8 secondary set", 6'h1C, 3'd4, 32'h8100_F0F0);

    io_fwd_off = 1;
    op(1, 6'h04, 3'd4, 32'h0);
    rd("R12 io enable frozen", 6'h04, 3'd4, 32'hF810_0001);
    op(1, 6'h1C, 3'd4, 32'h8000_0000);
    rd("R12 io base frozen, w1c works", 6'h1C, 3'd4, 32'h0100_F0F0);
    op(1, 6'h30, 3'd4, 32'h0);
    rd("R12 io upper frozen", 6'h30, 3'd4, 32'hCAFE_BEEF);
    io_fwd_off = 0;
    op(1, 6'h30, 3'd4, 32'h0);
    rd("R12 io upper writable again", 6'h30, 3'd4, 32'h0);

    pref_fwd_off = 1;
    op(1, 6'h24, 3'd4, 32'h0);
    rd("R13 pref frozen", 6'h24, 3'd4, 32'hFFF1_FFF1);
    op(1, 6'h28, 3'd4, 32'h0);
    rd("R10 upper32 still writable", 6'h28, 3'd4, 32'h0);
    pref_fwd_off = 0;
    op(1, 6'h24, 3'd4, 32'h0);
    rd("R13 pref writable again", 6'h24, 3'd4, 32'h0001_0001);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule